// File: doc/BRIEF.md
# Two-Digit Decimal Counter with Parallel Load

This block counts from 00 to 99 in decimal and starts again at 00. It is built from two single-digit decimal stages: ones and tens. Each stage holds a 4-bit digit in BCD, raises a flag while that digit is 9, and drives its own seven-segment pattern. The ones stage steps whenever counting is enabled. The tens stage steps only when counting is enabled and the ones digit stands at 9, so the tens digit moves at the moment the ones digit wraps.

A synchronous load writes both digits in one clock edge from an 8-bit value: the low nibble goes to the ones digit and the high nibble to the tens digit. The load overrides the count enable. An active-low asynchronous reset clears both digits at once. A digit loaded with a code from 10 to 15 shows a blank pattern, and it goes back to 0 on the next edge at which that digit steps. A carry output tells the next stage in a longer chain that this counter is about to wrap from 99 to 00.

Each stage decides what to do on every edge from a small enumerated set of operations: keep the digit, step it, or load it. Load comes first, then step, then keep. Stepping changes the digit in one of two ways: increment, or wrap to 0 when the digit is 9 or more.

Top module: `dec2_counter`

## Requirements
- R1: While `rst_n` is 0, both digits are 0 straight away, without waiting for a clock edge and whatever the other inputs are.
- R2: On a rising edge with `load` = 1, `ones_q` takes `load_val[3:0]` and `tens_q` takes `load_val[7:4]`, whatever the level of `cnt_en`.
- R3: On a rising edge with `load` = 0 and `cnt_en` = 0, both digits keep their values.
- R4: On a rising edge with `load` = 0 and `cnt_en` = 1, the ones digit goes from 0 to 8 up by one, and from 9 it goes to 0.
- R5: The tens digit steps (up by one, or from 9 to 0) only on an edge where `load` = 0, `cnt_en` = 1 and `ones_q` = 9. So 09 goes to 10 and 99 goes to 00. On any other edge without load it keeps its value.
- R6: `ones_tc` is 1 exactly when `ones_q` = 9, and `tens_tc` is 1 exactly when `tens_q` = 9.
- R7: `carry_out` is 1 exactly when `cnt_en` = 1 and both digits equal 9. It is combinational.
- R8: A digit holding a loaded value from 10 to 15 becomes 0 on the next edge at which it steps. Its terminal-count flag is 0 while it holds such a value.
- R9: The segment outputs are active-high, with bit 6 = a through bit 0 = g. They are combinational from the digits. The codes for digits 0..9 are 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F, 7B (hex).
- R10: For digit values 10 to 15 the segment output is 00 (blank).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable |
| load | input | 1 | Synchronous parallel load, has priority over cnt_en |
| load_val | input | 8 | Value to load: [7:4] tens, [3:0] ones |
| ones_q | output | 4 | Ones digit |
| tens_q | output | 4 | Tens digit |
| ones_tc | output | 1 | Ones digit equals 9 |
| tens_tc | output | 1 | Tens digit equals 9 |
| carry_out | output | 1 | Enable high and count at 99 |
| ones_seg | output | 7 | Ones seven-segment pattern, a..g = bit 6..0 |
| tens_seg | output | 7 | Tens seven-segment pattern, a..g = bit 6..0 |

## Verification
The hardest cases to reach are the ones that need a particular digit value before an edge. Examples are the double wrap from 99 to 00, and a tens digit holding a code from 10 to 15 at the moment the ones digit reaches 9. Counting up from reset to get there would take many edges and could never produce codes above 9. The bench therefore uses the parallel load to put the counter just before each case, for instance 98, F9 or 9C, and then applies one or two counting edges. Every segment code is reached the same way, by loading each value from 0 to 15 into both digits.

// File: rtl/dec2_pkg.sv
package dec2_pkg;
    localparam int DIGIT_W    = 4;
    localparam int SEG_W      = 7;
    localparam int NUM_DIGITS = 2;
    localparam int DIGIT_LAST = 9;
    localparam int BUS_W      = DIGIT_W * NUM_DIGITS;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [SEG_W-1:0]   seg_t;

    // Per-edge operation of one decimal stage, in priority order load > step > hold
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } stage_op_e;
endpackage

// File: rtl/dec2_stage.sv
module dec2_stage
    import dec2_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  logic   step_en,
    input  digit_t load_digit,
    output digit_t digit_q,
    output logic   tc
);
    localparam digit_t LAST = digit_t'(DIGIT_LAST);

    stage_op_e op;
    digit_t    digit_d;

    // Operation select
    always_comb begin
        if (load)
            op = OP_LOAD;
        else if (step_en)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end

    // Next digit for each operation
    always_comb begin
        unique case (op)
            OP_LOAD: digit_d = load_digit;
            OP_STEP: digit_d = (digit_q >= LAST) ? '0 : digit_q + digit_t'(1);
            OP_HOLD: digit_d = digit_q;
            default: digit_d = digit_q;
        endcase
    end

    // Digit register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            digit_q <= '0;
        else
            digit_q <= digit_d;
    end

    assign tc = (digit_q == LAST);
endmodule

// File: rtl/dec2_seg7.sv
module dec2_seg7
    import dec2_pkg::*;
(
    input  digit_t digit,
    output seg_t   seg
);
    // Active-high segments, bit 6 = a down to bit 0 = g
    always_comb begin
        case (digit)
            4'd0:    seg = 7'h7E;
            4'd1:    seg = 7'h30;
            4'd2:    seg = 7'h6D;
            4'd3:    seg = 7'h79;
            4'd4:    seg = 7'h33;
            4'd5:    seg = 7'h5B;
            4'd6:    seg = 7'h5F;
            4'd7:    seg = 7'h70;
            4'd8:    seg = 7'h7F;
            4'd9:    seg = 7'h7B;
            default: seg = 7'h00;
        endcase
    end
endmodule

// File: rtl/dec2_counter.sv
module dec2_counter
    import dec2_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             load,
    input  logic [BUS_W-1:0] load_val,
    output logic [3:0]       ones_q,
    output logic [3:0]       tens_q,
    output logic             ones_tc,
    output logic             tens_tc,
    output logic             carry_out,
    output logic [6:0]       ones_seg,
    output logic [6:0]       tens_seg
);
    digit_t digit  [NUM_DIGITS];
    seg_t   seg    [NUM_DIGITS];
    logic   tc     [NUM_DIGITS];
    logic   chain  [NUM_DIGITS+1];

    assign chain[0] = cnt_en;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
        dec2_stage u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .step_en    (chain[i]),
            .load_digit (load_val[i*DIGIT_W +: DIGIT_W]),
            .digit_q    (digit[i]),
            .tc         (tc[i])
        );

        dec2_seg7 u_seg (
            .digit (digit[i]),
            .seg   (seg[i])
        );

        // A higher stage steps only when every lower stage sits at 9
        assign chain[i+1] = chain[i] & tc[i];
    end

    assign ones_q    = digit[0];
    assign tens_q    = digit[1];
    assign ones_tc   = tc[0];
    assign tens_tc   = tc[1];
    assign ones_seg  = seg[0];
    assign tens_seg  = seg[1];
    assign carry_out = chain[NUM_DIGITS];
endmodule

// File: rtl/dec2_counter_chk.sv
module dec2_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_en,
    input logic       load,
    input logic [7:0] load_val,
    input logic [3:0] ones_q,
    input logic [3:0] tens_q,
    input logic       carry_out,
    input logic [6:0] ones_seg,
    input logic [6:0] tens_seg
);
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ones_q == 4'd0 && tens_q == 4'd0)); // R1
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ones_q == $past(load_val[3:0]) && tens_q == $past(load_val[7:4]))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !cnt_en) |=> ($stable(ones_q) && $stable(tens_q))); // R3
    AST_ONES_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_en && ones_q < 4'd9) |=> (ones_q == $past(ones_q) + 4'd1)); // R4
    AST_ONES_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_en && ones_q >= 4'd9) |=> (ones_q == 4'd0)); // R8
    AST_TENS_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_en && ones_q == 4'd9 && tens_q < 4'd9) |=> (tens_q == $past(tens_q) + 4'd1)); // R5
    AST_TENS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && ones_q != 4'd9) |=> $stable(tens_q)); // R5
    AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (cnt_en && ones_q == 4'd9 && tens_q == 4'd9)); // R7
    AST_SEG_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (ones_q > 4'd9) |-> (ones_seg == 7'h00)); // R10
    AST_SEG_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tens_q <= 4'd9) |-> (tens_seg != 7'h00)); // R9
endmodule

bind dec2_counter dec2_counter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .load      (load),
    .load_val  (load_val),
    .ones_q    (ones_q),
    .tens_q    (tens_q),
    .carry_out (carry_out),
    .ones_seg  (ones_seg),
    .tens_seg  (tens_seg)
);

// File: tb/dec2_counter_test.sv
`timescale 1ns/1ps
module dec2_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_val = 8'h00;
    logic [3:0] ones_q, tens_q;
    logic       ones_tc, tens_tc, carry_out;
    logic [6:0] ones_seg, tens_seg;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dec2_counter uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load(load), .load_val(load_val),
        .ones_q(ones_q), .tens_q(tens_q), .ones_tc(ones_tc), .tens_tc(tens_tc),
        .carry_out(carry_out), .ones_seg(ones_seg), .tens_seg(tens_seg)
    );

    function automatic logic [6:0] seg_of(input logic [3:0] d);
        logic [6:0] codes [10] = '{7'h7E, 7'h30, 7'h6D, 7'h79, 7'h33,
                                   7'h5B, 7'h5F, 7'h70, 7'h7F, 7'h7B};
        return (d <= 4'd9) ? codes[d] : 7'h00;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive inputs at negedge, apply one rising edge, settle
    task automatic tick(input logic en, input logic ld, input logic [7:0] v);
        @(negedge clk);
        cnt_en = en; load = ld; load_val = v;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        check("R1 ones after reset", ones_q, 0);
        check("R1 tens after reset", tens_q, 0);
        check("R9 seg at reset", ones_seg, 7'h7E);
    endtask

    task automatic t_load;
        tick(1'b0, 1'b1, 8'h47);
        check("R2 load ones en=0", ones_q, 7);
        check("R2 load tens en=0", tens_q, 4);
        tick(1'b1, 1'b1, 8'h25);
        check("R2 load over enable", {tens_q, ones_q}, 8'h25);
    endtask

    task automatic t_hold;
        tick(1'b0, 1'b0, 8'h99);
        check("R3 hold", {tens_q, ones_q}, 8'h25);
        tick(1'b0, 1'b0, 8'h00);
        check("R3 hold twice", {tens_q, ones_q}, 8'h25);
    endtask

    task automatic t_ones;
        tick(1'b0, 1'b1, 8'h30);
        for (int k = 1; k <= 10; k++) begin
            tick(1'b1, 1'b0, 8'h00);
            check("R4 ones count", ones_q, k % 10);
            check("R6 ones tc", ones_tc, (k % 10) == 9);
        end
        check("R5 tens after ones wrap", tens_q, 4);
    endtask

    task automatic t_chain;
        tick(1'b0, 1'b1, 8'h09);
        check("R6 tens tc low", tens_tc, 0);
        tick(1'b1, 1'b0, 8'h00);
        check("R5 09 to 10", {tens_q, ones_q}, 8'h10);
        tick(1'b0, 1'b1, 8'h98);
        @(negedge clk); cnt_en = 1'b1; load = 1'b0; #1;
        check("R7 carry low at 98", carry_out, 0);
        @(posedge clk); #1;
        check("R6 both tc at 99", {tens_tc, ones_tc}, 2'b11);
        check("R7 carry at 99", carry_out, 1);
        @(negedge clk); cnt_en = 1'b0; #1;
        check("R7 carry needs enable", carry_out, 0);
        tick(1'b1, 1'b0, 8'h00);
        check("R5 99 to 00", {tens_q, ones_q}, 8'h00);
    endtask

    task automatic t_invalid;
        tick(1'b0, 1'b1, 8'h9C);
        check("R8 tc low on code 12", ones_tc, 0);
        check("R10 blank ones", ones_seg, 7'h00);
        tick(1'b1, 1'b0, 8'h00);
        check("R8 code 12 returns to 0", ones_q, 0);
        check("R5 tens kept", tens_q, 9);
        tick(1'b0, 1'b1, 8'hF9);
        check("R10 blank tens", tens_seg, 7'h00);
        tick(1'b1, 1'b0, 8'h00);
        check("R8 tens code 15 to 0", {tens_q, ones_q}, 8'h00);
    endtask

    task automatic t_segments;
        for (int d = 0; d < 16; d++) begin
            tick(1'b0, 1'b1, {4'(15 - d), 4'(d)});
            check(d <= 9 ? "R9 ones seg" : "R10 ones seg", ones_seg, seg_of(4'(d)));
            check((15 - d) <= 9 ? "R9 tens seg" : "R10 tens seg", tens_seg, seg_of(4'(15 - d)));
        end
    endtask

    task automatic t_async_reset;
        tick(1'b0, 1'b1, 8'h57);
        @(negedge clk); #0.5;
        rst_n = 1'b0;
        #0.5;
        check("R1 async clear", {tens_q, ones_q}, 8'h00);
        @(negedge clk);
        cnt_en = 1'b1; load = 1'b1; load_val = 8'h66;
        @(posedge clk); #1;
        check("R1 reset beats load", {tens_q, ones_q}, 8'h00);
        @(negedge clk); load = 1'b0; cnt_en = 1'b0; rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_load();
        t_hold();
        t_ones();
        t_chain();
        t_invalid();
        t_segments();
        t_async_reset();
        tick(1'b1, 1'b0, 8'h00);
        check("R4 count after reset", ones_q, 1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule